// File: doc/BRIEF.md
# Vertical Blank Timing and NMI Source

This block supplies the frame timing of a tile-based video processor and raises the vertical-blank interrupt for the host CPU. A dot counter and a scanline counter advance once per clock. They mark a fixed dot late in the frame where a vertical-blank status flag becomes set, and a later dot where it is cleared again. When the counters wrap back to the top of the frame, a one-clock frame-done pulse is issued.

The interrupt line `nmi_n` is active low. It is low while the flag is set and software has enabled the interrupt through bit 7 of the control register at address 0. Reading the status register at address 2 returns the flag in bit 7 and clears it, which acknowledges the interrupt. A status read that lands within one dot of the set point suppresses that frame's interrupt. Disabling and then re-enabling the interrupt while the flag is still pending produces a fresh falling edge on the line.

In the requirements, S is the dot where the scanline counter equals the set line and the dot counter equals the event dot (default: scanline 241, dot 1). C is the same dot position on the clear line (default: scanline 261, dot 1). Offsets such as S+2 count whole dots.

Top module: `vbl_nmi_gen`

## Requirements
- R1: The dot counter runs from 0 to DOTS_PER_LINE-1 (default 341) and then advances the scanline. The scanline counter runs from 0 to LINES_PER_FRAME-1 (default 262) and wraps to 0. `frame_done` is high for exactly the first dot of every frame after the first, so it repeats every DOTS_PER_LINE*LINES_PER_FRAME clocks.
- R2: The flag becomes set at dot S. A status read on dot S or later in vertical blank returns 0x80, and a read on dot S-2 returns 0x00.
- R3: The flag is cleared at dot C. A read on dot C+1 returns 0x00, and an asserted `nmi_n` returns high on dot C+2.
- R4: A single-dot access with `cpu_sel`=1, `cpu_we`=0 and `cpu_addr`=2 returns the flag in bit 7 with all other bits 0, and clears the flag. A read at any other address returns 0x00 and leaves the flag untouched.
- R5: A write (`cpu_sel`=1, `cpu_we`=1) to address 0 loads the interrupt enable from `cpu_wdata` bit 7. The other data bits, and writes to any other address, have no effect on the enable.
- R6: With the enable set, `nmi_n` goes low on dot S+2. A status read on dot r makes `nmi_n` high from dot r+1.
- R7: A status read on dot S-1 returns 0x00 and stops the flag from being set in that frame, so a later read returns 0x00 and `nmi_n` stays high for the whole frame.
- R8: A status read on dot S or on dot S+1 returns 0x80, and `nmi_n` never goes low in that frame.
- R9: A status read on dot S-2 or earlier leaves the interrupt of that frame intact. A read on dot S+2 or later comes after `nmi_n` has already gone low.
- R10: With the flag pending, a write of enable=0 on dot w makes `nmi_n` high from dot w+2. A following write of enable=1 on dot v makes it low again from dot v+2.
- R11: While `rst_n` is low, `nmi_n` is high and `frame_done` is low. Reset clears the counters, the flag and the enable, so the first status read after reset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock; one dot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_sel | input | 1 | Register access strobe, held for one dot per access |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 3 | Register address (0 control, 2 status) |
| cpu_wdata | input | 8 | Write data; bit 7 is the interrupt enable |
| cpu_rdata | output | 8 | Read data, valid in the same dot as the access |
| nmi_n | output | 1 | Active-low vertical-blank interrupt, registered |
| frame_done | output | 1 | One-dot pulse at the first dot of each frame |

## Verification
The status read is placed at each dot from S-2 to S+2. These five placements separate the dot that blocks the set, the two dots that acknowledge the flag before the interrupt can rise, and the two outer dots that leave the interrupt alone. Frames with no read at all pin down the rise and fall dots of `nmi_n` against the flag's set and clear points. Frames with the enable off, or with accesses to unrelated addresses, show that only the enable gates the line and only the status address clears the flag. A disable and re-enable on a pending flag, followed by a reset in the middle of vertical blank, checks that the line follows the enable in both directions and that reset wipes the pending state.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

  // Kind of CPU register access seen in the current dot.
  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_CTRL_WR,
    ACC_STAT_RD,
    ACC_OTHER
  } vbl_access_e;

  // Frame geometry defaults.
  localparam int unsigned DEF_DOTS_PER_LINE   = 341;
  localparam int unsigned DEF_LINES_PER_FRAME = 262;
  localparam int unsigned DEF_SET_LINE        = 241;
  localparam int unsigned DEF_CLR_LINE        = 261;
  localparam int unsigned DEF_EVENT_DOT       = 1;

endpackage

// File: rtl/vbl_frame_timer.sv
module vbl_frame_timer #(
  parameter int unsigned DOTS_PER_LINE   = vbl_pkg::DEF_DOTS_PER_LINE,
  parameter int unsigned LINES_PER_FRAME = vbl_pkg::DEF_LINES_PER_FRAME,
  parameter int unsigned SET_LINE        = vbl_pkg::DEF_SET_LINE,
  parameter int unsigned CLR_LINE        = vbl_pkg::DEF_CLR_LINE,
  parameter int unsigned EVENT_DOT       = vbl_pkg::DEF_EVENT_DOT
) (
  input  logic clk,
  input  logic rst_n,
  output logic at_pre_set_o,
  output logic at_set_o,
  output logic at_clr_o,
  output logic frame_done_o
);

  localparam int unsigned DOT_W  = (DOTS_PER_LINE > 1) ? $clog2(DOTS_PER_LINE) : 1;
  localparam int unsigned LINE_W = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1;

  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FRAME - 1);
  localparam logic [DOT_W-1:0]  EV_DOT    = DOT_W'(EVENT_DOT);
  localparam logic [LINE_W-1:0] SET_LN    = LINE_W'(SET_LINE);
  localparam logic [LINE_W-1:0] CLR_LN    = LINE_W'(CLR_LINE);
  // Dot just ahead of the set point; steps back a line when the event is dot 0.
  localparam logic [DOT_W-1:0]  PRE_DOT   = (EVENT_DOT == 0) ? DOT_LAST : DOT_W'(EVENT_DOT - 1);
  localparam logic [LINE_W-1:0] PRE_LN    = (EVENT_DOT == 0) ? LINE_W'(SET_LINE - 1) : SET_LN;

  logic [DOT_W-1:0]  dot_q,  dot_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              done_q, done_d;

  // Next-state
  always_comb begin
    dot_d  = dot_q + 1'b1;
    line_d = line_q;
    done_d = 1'b0;
    if (dot_q == DOT_LAST) begin
      dot_d = '0;
      if (line_q == LINE_LAST) begin
        line_d = '0;
        done_d = 1'b1;
      end else begin
        line_d = line_q + 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
      done_q <= 1'b0;
    end else begin
      dot_q  <= dot_d;
      line_q <= line_d;
      done_q <= done_d;
    end
  end

  assign at_pre_set_o = (line_q == PRE_LN) && (dot_q == PRE_DOT);
  assign at_set_o     = (line_q == SET_LN) && (dot_q == EV_DOT);
  assign at_clr_o     = (line_q == CLR_LN) && (dot_q == EV_DOT);
  assign frame_done_o = done_q;

  a_r1_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_q == DOT_LAST) |=> (dot_q == '0));

  a_r1_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_q == DOT_LAST && line_q != LINE_LAST) |=> (line_q == $past(line_q) + 1'b1));

  a_r1_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_q != DOT_LAST) |=> $stable(line_q));

  a_r1_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (dot_q == '0 && line_q == '0));

endmodule

// File: rtl/vbl_cpu_decode.sv
module vbl_cpu_decode #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 2
) (
  input  logic                  sel_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output vbl_pkg::vbl_access_e  acc_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  always_comb begin
    acc_o = vbl_pkg::ACC_IDLE;
    if (sel_i) begin
      if (we_i && addr_i == CTRL_A)       acc_o = vbl_pkg::ACC_CTRL_WR;
      else if (!we_i && addr_i == STAT_A) acc_o = vbl_pkg::ACC_STAT_RD;
      else                                acc_o = vbl_pkg::ACC_OTHER;
    end
  end

  a_r4_decode_idle: assert final (sel_i || acc_o == vbl_pkg::ACC_IDLE);

endmodule

// File: rtl/vbl_status_flag.sv
module vbl_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic at_pre_set_i,
  input  logic at_set_i,
  input  logic at_clr_i,
  input  logic rd_i,
  output logic flag_o,
  output logic flag_rd_o
);

  logic flag_q, flag_d;
  logic pre_rd_q, pre_rd_d;
  logic set_eff;

  // A read on the dot before the set point cancels that frame's set.
  assign set_eff = at_set_i & ~pre_rd_q;

  // Next-state: an acknowledge wins over the set, the clear point over the set.
  always_comb begin
    pre_rd_d = rd_i & at_pre_set_i;
    flag_d   = flag_q;
    if (rd_i)          flag_d = 1'b0;
    else if (at_clr_i) flag_d = 1'b0;
    else if (set_eff)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      pre_rd_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      pre_rd_q <= pre_rd_d;
    end
  end

  assign flag_o    = flag_q;
  assign flag_rd_o = flag_q | set_eff;

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !flag_q);

  a_r3_clear_point: assert property (@(posedge clk) disable iff (!rst_n)
    at_clr_i |=> !flag_q);

  a_r2_set_point: assert property (@(posedge clk) disable iff (!rst_n)
    (at_set_i && !rd_i && !at_clr_i && !$past(rd_i && at_pre_set_i)) |=> flag_q);

  a_r7_pre_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && at_pre_set_i) |=> ##1 !flag_q);

endmodule

// File: rtl/vbl_nmi_drive.sv
module vbl_nmi_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr_i,
  input  logic en_wbit_i,
  input  logic flag_i,
  input  logic rd_i,
  output logic nmi_n_o
);

  logic en_q, en_d;
  logic nmi_n_q, nmi_n_d;

  // Next-state: the enable loads only on a control write; the line is armed
  // from the registered flag and enable and dropped at once by an acknowledge.
  always_comb begin
    en_d = en_q;
    if (ctrl_wr_i) en_d = en_wbit_i;
    nmi_n_d = ~(en_q & flag_i & ~rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      nmi_n_q <= 1'b1;
    end else begin
      en_q    <= en_d;
      nmi_n_q <= nmi_n_d;
    end
  end

  assign nmi_n_o = nmi_n_q;

  a_r6_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_i |=> nmi_n_q);

  a_r6_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> nmi_n_q);

  a_r10_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> nmi_n_q);

  a_r10_enable_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> (en_q == $past(en_wbit_i)));

  a_r5_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_i |=> $stable(en_q));

endmodule

// File: rtl/vbl_nmi_gen.sv
module vbl_nmi_gen #(
  parameter int unsigned DOTS_PER_LINE   = vbl_pkg::DEF_DOTS_PER_LINE,
  parameter int unsigned LINES_PER_FRAME = vbl_pkg::DEF_LINES_PER_FRAME,
  parameter int unsigned SET_LINE        = vbl_pkg::DEF_SET_LINE,
  parameter int unsigned CLR_LINE        = vbl_pkg::DEF_CLR_LINE,
  parameter int unsigned EVENT_DOT       = vbl_pkg::DEF_EVENT_DOT,
  parameter int unsigned ADDR_W          = 3,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned CTRL_ADDR       = 0,
  parameter int unsigned STAT_ADDR       = 2,
  parameter int unsigned FLAG_BIT        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              nmi_n,
  output logic              frame_done
);

  vbl_pkg::vbl_access_e acc;
  logic at_pre_set, at_set, at_clr;
  logic rd_status, ctrl_wr;
  logic flag, flag_rd;
  logic unused_wbits;

  vbl_frame_timer #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .SET_LINE       (SET_LINE),
    .CLR_LINE       (CLR_LINE),
    .EVENT_DOT      (EVENT_DOT)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .at_pre_set_o(at_pre_set),
    .at_set_o    (at_set),
    .at_clr_o    (at_clr),
    .frame_done_o(frame_done)
  );

  vbl_cpu_decode #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .sel_i (cpu_sel),
    .we_i  (cpu_we),
    .addr_i(cpu_addr),
    .acc_o (acc)
  );

  assign rd_status = (acc == vbl_pkg::ACC_STAT_RD);
  assign ctrl_wr   = (acc == vbl_pkg::ACC_CTRL_WR);

  vbl_status_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .at_pre_set_i(at_pre_set),
    .at_set_i    (at_set),
    .at_clr_i    (at_clr),
    .rd_i        (rd_status),
    .flag_o      (flag),
    .flag_rd_o   (flag_rd)
  );

  vbl_nmi_drive u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr_i(ctrl_wr),
    .en_wbit_i(cpu_wdata[FLAG_BIT]),
    .flag_i   (flag),
    .rd_i     (rd_status),
    .nmi_n_o  (nmi_n)
  );

  // Only the enable bit of the write data is stored.
  assign unused_wbits = ^cpu_wdata;

  assign cpu_rdata = rd_status ? (DATA_W'(flag_rd) << FLAG_BIT) : '0;

endmodule

// File: tb/test_vbl_nmi_gen.sv
`timescale 1ns/1ps
module test_vbl_nmi_gen;

  localparam int D  = 16;
  localparam int L  = 10;
  localparam int SL = 7;
  localparam int CL = 9;
  localparam int ED = 1;
  localparam int FRAME = D * L;
  localparam int S = SL * D + ED;
  localparam int C = CL * D + ED;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_sel, cpu_we;
  logic [2:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       nmi_n, frame_done;

  int vectors = 0;
  int fails   = 0;
  int dots;
  bit saw_nmi;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vbl_nmi_gen #(
    .DOTS_PER_LINE(D), .LINES_PER_FRAME(L), .SET_LINE(SL),
    .CLR_LINE(CL), .EVENT_DOT(ED)
  ) i_vbl_nmi_gen (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .nmi_n(nmi_n), .frame_done(frame_done)
  );

  // Independent dot count since reset release.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) dots <= 0;
    else        dots <= dots + 1;
  end

  always @(negedge clk) begin
    if (rst_n && !nmi_n) saw_nmi = 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at dot %0d", tag, act, exp, dots % FRAME);
    end
  endtask

  task automatic goto(input int pos);
    do @(negedge clk); while ((dots % FRAME) != pos);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0; cpu_wdata = 8'h00;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1 v = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rst_n = 1'b0; cpu_sel = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 nmi_n in reset", nmi_n, 1);
    chk("R11 frame_done in reset", frame_done, 0);
    rst_n = 1'b1;
    goto(3);
    rd(3'd2, v);
    chk("R11 status after reset", v, 8'h00);
  endtask

  task automatic t_frame_done;
    for (int i = 0; i < 2 * FRAME; i++) begin
      @(negedge clk);
      chk("R1 frame_done", frame_done, ((dots % FRAME) == 0) ? 1 : 0);
    end
  endtask

  task automatic t_nmi_timing;
    goto(5); wr(3'd0, 8'h80);
    goto(S + 1); chk("R6 nmi_n before rise", nmi_n, 1);
    goto(S + 2); chk("R6 nmi_n falls at S+2", nmi_n, 0);
    goto(C + 1); chk("R3 nmi_n still low at C+1", nmi_n, 0);
    goto(C + 2); chk("R3 nmi_n released at C+2", nmi_n, 1);
  endtask

  task automatic t_flag_points;
    logic [7:0] v;
    goto(5); wr(3'd0, 8'h00);
    goto(S - 2); rd(3'd2, v); chk("R2 read at S-2", v, 8'h00);
    goto(S);     rd(3'd2, v); chk("R2 read at S", v, 8'h80);
    goto(5);
    goto(C + 1); rd(3'd2, v); chk("R3 read at C+1", v, 8'h00);
  endtask

  task automatic t_status_read;
    logic [7:0] v;
    goto(5); wr(3'd0, 8'h80);
    goto(S + 4); chk("R6 nmi_n low before ack", nmi_n, 0);
    rd(3'd2, v);
    chk("R4 status value", v, 8'h80);
    chk("R6 ack releases nmi_n", nmi_n, 1);
    goto(S + 7); rd(3'd2, v); chk("R4 flag cleared by read", v, 8'h00);
  endtask

  task automatic t_other_addr;
    logic [7:0] v;
    goto(5); wr(3'd0, 8'h00);
    goto(7); wr(3'd1, 8'h80);
    goto(9); wr(3'd3, 8'h80);
    goto(11); wr(3'd0, 8'h7F);
    goto(S + 4); chk("R5 enable untouched", nmi_n, 1);
    goto(S + 5); rd(3'd0, v); chk("R4 read addr 0", v, 8'h00);
    goto(S + 7); rd(3'd3, v); chk("R4 read addr 3", v, 8'h00);
    goto(S + 9); rd(3'd2, v); chk("R4 flag kept by other reads", v, 8'h80);
  endtask

  task automatic t_offset(input int d);
    logic [7:0] v;
    goto(5); wr(3'd0, 8'h80);
    goto(20); saw_nmi = 1'b0;
    goto(S + d); rd(3'd2, v);
    if (d < 0) chk((d == -1) ? "R7 read value at S-1" : "R9 read value at S-2", v, 8'h00);
    else       chk((d < 2) ? "R8 read value near set" : "R9 read value at S+2", v, 8'h80);
    if (d == -1) begin
      goto(S + 3); rd(3'd2, v); chk("R7 set blocked", v, 8'h00);
    end
    goto(C + 4);
    if (d >= -1 && d <= 1) chk((d == -1) ? "R7 no nmi" : "R8 no nmi", saw_nmi, 0);
    else                   chk("R9 nmi taken", saw_nmi, 1);
  endtask

  task automatic t_reenable;
    goto(5); wr(3'd0, 8'h80);
    goto(S + 3); chk("R10 nmi_n low first", nmi_n, 0);
    goto(S + 4); wr(3'd0, 8'h00);
    goto(S + 6); chk("R10 disable releases", nmi_n, 1);
    goto(S + 8); wr(3'd0, 8'h80);
    chk("R10 still high at v+1", nmi_n, 1);
    goto(S + 10); chk("R10 fresh edge at v+2", nmi_n, 0);
  endtask

  task automatic t_reset_mid;
    logic [7:0] v;
    goto(5); wr(3'd0, 8'h80);
    goto(S + 3); chk("R11 nmi_n low before reset", nmi_n, 0);
    rst_n = 1'b0;
    #1;
    chk("R11 reset releases nmi_n", nmi_n, 1);
    chk("R11 reset frame_done", frame_done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    goto(3); rd(3'd2, v); chk("R11 flag cleared by reset", v, 8'h00);
    goto(S + 3); chk("R11 enable cleared by reset", nmi_n, 1);
    rd(3'd2, v); chk("R11 flag sets after reset", v, 8'h80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame_done();
    t_nmi_timing();
    t_flag_points();
    t_status_read();
    t_other_addr();
    for (int d = -2; d <= 2; d++) t_offset(d);
    t_reenable();
    t_reset_mid();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule